// File: doc/BRIEF.md
# Delayed-Branch and Exception Sequencer

This block produces the fetch program counter for a processor whose branches carry a single delay slot. Each time an instruction retires, the block receives the instruction's class, a displacement or precomputed target, a register operand and the current T flag. A branch does not redirect fetch when it retires. It records a pending target and, for the conditional forms, whether the branch is taken. The instruction that follows, the delay slot, retires next, and only then does the program counter move to the recorded target. If the branch is not taken, the program counter moves on sequentially instead.

The block holds the following state:

- the pending target;
- the slot-taken flag;
- the subroutine return register;
- the status register;
- a saved status and a saved program counter, used when an exception is taken;
- the trap operand.

Traps, illegal instructions and instructions that are not allowed in a delay slot each raise an exception. An exception drives a one-cycle request together with a code, saves the machine state and cancels any pending branch. Vector lookup and privilege checks are left to surrounding logic.

Top module: `dslot_seq`

## Requirements
- R1: After reset is released, the fetch PC equals parameter RESET_PC (0x1000 by default), the status register reads 0x700000F0, the trap operand is 0, and the exception request and code are 0. With retire_i low, no state changes.
- R2: With no branch pending, each retired instruction of class 0 (sequential) or class 13 (status write) advances the PC by 2.
- R3: Class 1 (target = displacement), class 2 (target = displacement + register) and class 3 (target = register) are unconditional delayed branches. The PC first steps by 2 to the slot instruction. When the slot instruction retires, the PC becomes the target.
- R4: Class 4 is taken only when t_i is 1, and class 5 only when t_i is 0. Both use the displacement as the target. When not taken, the PC simply steps by 2 past the slot.
- R5: Class 6 (target = displacement), class 7 (target = displacement + register) and class 8 (target = register) write the return register with the branch PC + 4 and branch like R3. Class 9 branches to the return register.
- R6: Class 10 copies the saved status into the status register immediately. After its slot, the PC becomes the saved PC.
- R7: Class 11 (trap) loads the trap operand with disp_i[7:0] shifted left by 2 and raises code 0x160.
- R8: Class 12, and the unused classes 14 and 15, raise code 0x180 outside a slot. Any class 1 to 12 retiring inside a delay slot raises code 0x1A0.
- R9: Class 13 writes the status register with reg_i AND 0x700083F3.
- R10: On an exception, the PC holds its value, the saved PC takes the current PC and the saved status takes the current status register. The request pulses high for exactly one cycle after the retiring edge, and the code is 0 whenever the request is low.
- R11: An exception in a delay slot cancels the pending branch. After any slot has been used, the next instruction steps sequentially by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| retire_i | input | 1 | Strobe: the instruction at pc_o completes this cycle |
| cls_i | input | 4 | Instruction class code |
| disp_i | input | W | Displacement, precomputed target or trap immediate |
| reg_i | input | W | Register operand |
| t_i | input | 1 | Current T condition flag |
| pc_o | output | W | Fetch program counter |
| sr_o | output | 32 | Status register |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_code_o | output | 12 | Exception code, 0 when no request |
| tra_o | output | W | Trap operand register |

## Verification
The assertions assume that cls_i, disp_i, reg_i and t_i are stable and valid at every clock edge where retire_i is high. They also assume that the instruction retiring is the one at pc_o, so the PC relations hold edge to edge. The bench changes every input only at the falling clock edge and raises retire_i for exactly one rising edge per instruction. It follows each branch with its slot instruction, except where a misplaced branch inside a slot is the point of the test.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  typedef enum logic [3:0] {
    CL_NEXT = 4'd0,
    CL_BRA  = 4'd1,
    CL_BRAR = 4'd2,
    CL_JMP  = 4'd3,
    CL_BT   = 4'd4,
    CL_BF   = 4'd5,
    CL_CALL = 4'd6,
    CL_CALR = 4'd7,
    CL_JSUB = 4'd8,
    CL_RET  = 4'd9,
    CL_ERET = 4'd10,
    CL_TRAP = 4'd11,
    CL_ILL  = 4'd12,
    CL_SRWR = 4'd13,
    CL_RS14 = 4'd14,
    CL_RS15 = 4'd15
  } cls_e;

  localparam logic [31:0] SR_WMASK = 32'h7000_83F3;
  localparam logic [31:0] SR_RST   = 32'h7000_00F0;

  localparam int unsigned EXC_W = 12;
  localparam logic [EXC_W-1:0] EXC_TRAP = 12'h160;
  localparam logic [EXC_W-1:0] EXC_ILL  = 12'h180;
  localparam logic [EXC_W-1:0] EXC_SLOT = 12'h1A0;

endpackage

// File: rtl/dslot_decode.sv
module dslot_decode
  import dslot_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [3:0]   cls_i,
  input  logic [W-1:0] disp_i,
  input  logic [W-1:0] reg_i,
  input  logic         t_i,
  input  logic [W-1:0] pr_i,
  input  logic [W-1:0] spc_i,
  output logic         brn_o,
  output logic         take_o,
  output logic         link_o,
  output logic         eret_o,
  output logic         trap_o,
  output logic         ill_o,
  output logic         srwr_o,
  output logic [W-1:0] tgt_o
);

  cls_e cls;
  assign cls = cls_e'(cls_i);

  always_comb begin
    brn_o  = 1'b0;
    take_o = 1'b0;
    link_o = 1'b0;
    eret_o = 1'b0;
    trap_o = 1'b0;
    ill_o  = 1'b0;
    srwr_o = 1'b0;
    tgt_o  = disp_i;
    unique case (cls)
      CL_NEXT: ;
      CL_BRA:  begin brn_o = 1'b1; take_o = 1'b1; end
      CL_BRAR: begin brn_o = 1'b1; take_o = 1'b1; tgt_o = disp_i + reg_i; end
      CL_JMP:  begin brn_o = 1'b1; take_o = 1'b1; tgt_o = reg_i; end
      CL_BT:   begin brn_o = 1'b1; take_o = t_i; end
      CL_BF:   begin brn_o = 1'b1; take_o = ~t_i; end
      CL_CALL: begin brn_o = 1'b1; take_o = 1'b1; link_o = 1'b1; end
      CL_CALR: begin brn_o = 1'b1; take_o = 1'b1; link_o = 1'b1; tgt_o = disp_i + reg_i; end
      CL_JSUB: begin brn_o = 1'b1; take_o = 1'b1; link_o = 1'b1; tgt_o = reg_i; end
      CL_RET:  begin brn_o = 1'b1; take_o = 1'b1; tgt_o = pr_i; end
      CL_ERET: begin brn_o = 1'b1; take_o = 1'b1; eret_o = 1'b1; tgt_o = spc_i; end
      CL_TRAP: trap_o = 1'b1;
      CL_SRWR: srwr_o = 1'b1;
      default: ill_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/dslot_trap.sv
module dslot_trap
  import dslot_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             in_slot_i,
  input  logic             brn_i,
  input  logic             trap_i,
  input  logic             ill_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [W-1:0]     pc_i,
  input  logic [31:0]      sr_i,
  output logic             exc_now_o,
  output logic             exc_req_o,
  output logic [EXC_W-1:0] exc_code_o,
  output logic [31:0]      ssr_o,
  output logic [W-1:0]     spc_o,
  output logic [W-1:0]     tra_o
);

  localparam int unsigned SH = 2;

  logic             slot_bad;
  logic [EXC_W-1:0] code_sel;
  logic             req_d;
  logic [EXC_W-1:0] code_d;
  logic [31:0]      ssr_d;
  logic [W-1:0]     spc_d, tra_d;

  assign slot_bad  = in_slot_i & (brn_i | trap_i | ill_i);
  assign exc_now_o = retire_i & (slot_bad | ill_i | trap_i);

  always_comb begin
    if (slot_bad)   code_sel = EXC_SLOT;
    else if (ill_i) code_sel = EXC_ILL;
    else            code_sel = EXC_TRAP;
  end

  always_comb begin
    req_d  = exc_now_o;
    code_d = exc_now_o ? code_sel : '0;
    ssr_d  = ssr_o;
    spc_d  = spc_o;
    tra_d  = tra_o;
    if (exc_now_o) begin
      ssr_d = sr_i;
      spc_d = pc_i;
      if (!slot_bad && trap_i) tra_d = W'({imm_i, {SH{1'b0}}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req_o  <= 1'b0;
      exc_code_o <= '0;
      ssr_o      <= '0;
      spc_o      <= '0;
      tra_o      <= '0;
    end else begin
      exc_req_o  <= req_d;
      exc_code_o <= code_d;
      if (exc_now_o) begin
        ssr_o <= ssr_d;
        spc_o <= spc_d;
        tra_o <= tra_d;
      end
    end
  end

  // R10: the code is zero whenever no request is raised
  a_r10_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req_o |-> (exc_code_o == '0));

  // R8: the request carries one of the three defined codes
  a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> (exc_code_o == EXC_TRAP || exc_code_o == EXC_ILL || exc_code_o == EXC_SLOT));

  // R10: saved PC follows the faulting PC
  a_r10_spc_save: assert property (@(posedge clk) disable iff (!rst_n)
    exc_now_o |=> (spc_o == $past(pc_i)));

endmodule

// File: rtl/dslot_seq.sv
module dslot_seq
  import dslot_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned IMM_W    = 8,
  parameter logic [W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic [3:0]       cls_i,
  input  logic [W-1:0]     disp_i,
  input  logic [W-1:0]     reg_i,
  input  logic             t_i,
  output logic [W-1:0]     pc_o,
  output logic [31:0]      sr_o,
  output logic             exc_req_o,
  output logic [EXC_W-1:0] exc_code_o,
  output logic [W-1:0]     tra_o
);

  localparam logic [W-1:0] STEP = W'(2);
  localparam logic [W-1:0] LINK = W'(4);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic [W-1:0] pc_q, pc_d, dpc_q, dpc_d, pr_q, pr_d;
  logic         slot_q, slot_d, tkn_q, tkn_d;
  logic [31:0]  sr_q, sr_d;

  logic         d_brn, d_take, d_link, d_eret, d_trap, d_ill, d_srwr;
  logic [W-1:0] tgt;
  logic         exc_now;
  logic [31:0]  ssr;
  logic [W-1:0] spc;

  dslot_decode #(.W(W)) u_dec (
    .cls_i  (cls_i),
    .disp_i (disp_i),
    .reg_i  (reg_i),
    .t_i    (t_i),
    .pr_i   (pr_q),
    .spc_i  (spc),
    .brn_o  (d_brn),
    .take_o (d_take),
    .link_o (d_link),
    .eret_o (d_eret),
    .trap_o (d_trap),
    .ill_o  (d_ill),
    .srwr_o (d_srwr),
    .tgt_o  (tgt)
  );

  dslot_trap #(.W(W), .IMM_W(IMM_W)) u_trap (
    .clk        (clk),
    .rst_n      (rst_ni),
    .retire_i   (retire_i),
    .in_slot_i  (slot_q),
    .brn_i      (d_brn),
    .trap_i     (d_trap),
    .ill_i      (d_ill),
    .imm_i      (disp_i[IMM_W-1:0]),
    .pc_i       (pc_q),
    .sr_i       (sr_q),
    .exc_now_o  (exc_now),
    .exc_req_o  (exc_req_o),
    .exc_code_o (exc_code_o),
    .ssr_o      (ssr),
    .spc_o      (spc),
    .tra_o      (tra_o)
  );

  always_comb begin
    pc_d   = pc_q;
    dpc_d  = dpc_q;
    slot_d = slot_q;
    tkn_d  = tkn_q;
    pr_d   = pr_q;
    sr_d   = sr_q;
    if (exc_now) begin
      slot_d = 1'b0;
      tkn_d  = 1'b0;
    end else begin
      if (slot_q) begin
        pc_d   = tkn_q ? dpc_q : pc_q + STEP;
        slot_d = 1'b0;
        tkn_d  = 1'b0;
      end else begin
        pc_d = pc_q + STEP;
        if (d_brn) begin
          slot_d = 1'b1;
          tkn_d  = d_take;
          dpc_d  = tgt;
        end
        if (d_link) pr_d = pc_q + LINK;
      end
      if (d_eret)      sr_d = ssr;
      else if (d_srwr) sr_d = SR_WMASK & 32'(reg_i);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_PC;
      dpc_q  <= '0;
      slot_q <= 1'b0;
      tkn_q  <= 1'b0;
      pr_q   <= '0;
      sr_q   <= SR_RST;
    end else if (retire_i) begin
      pc_q   <= pc_d;
      dpc_q  <= dpc_d;
      slot_q <= slot_d;
      tkn_q  <= tkn_d;
      pr_q   <= pr_d;
      sr_q   <= sr_d;
    end
  end

  assign pc_o = pc_q;
  assign sr_o = sr_q;

  // R2: sequential step when no slot is pending
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (retire_i && !slot_q && !exc_now) |=> (pc_q == $past(pc_q) + STEP));

  // R3: a taken slot redirects to the recorded target
  a_r3_redirect: assert property (@(posedge clk) disable iff (!rst_ni)
    (retire_i && slot_q && tkn_q && !exc_now) |=> (pc_q == $past(dpc_q)));

  // R11: an exception cancels the pending slot and holds the PC
  a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_ni)
    (retire_i && exc_now) |=> (!slot_q && !tkn_q && pc_q == $past(pc_q)));

  // R9: status register never holds bits outside the writable mask
  a_r9_sr_mask: assert property (@(posedge clk) disable iff (!rst_ni)
    ((sr_o & ~SR_WMASK) == 32'h0));

  // R1: nothing moves without a retire strobe
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !retire_i |=> ($stable(pc_q) && $stable(sr_q)));

endmodule

// File: tb/tb_dslot_seq.sv
module tb_dslot_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire = 1'b0;
  logic [3:0]  cls = 4'd0;
  logic [31:0] disp = '0, rg = '0;
  logic        t = 1'b0;
  logic [31:0] pc, sr, tra;
  logic        req;
  logic [11:0] code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslot_seq dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .cls_i(cls),
    .disp_i(disp), .reg_i(rg), .t_i(t), .pc_o(pc), .sr_o(sr),
    .exc_req_o(req), .exc_code_o(code), .tra_o(tra)
  );

  // {class[100:97], disp[96:65], reg[64:33], t[32], expected pc[31:0]}
  localparam logic [100:0] VEC [NV] = '{
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h1002},
    {4'd1,  32'h2000, 32'h0,    1'b0, 32'h1004},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h2000},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h2002},
    {4'd4,  32'h3000, 32'h0,    1'b1, 32'h2004},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h3000},
    {4'd4,  32'h4000, 32'h0,    1'b0, 32'h3002},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h3004},
    {4'd5,  32'h4000, 32'h0,    1'b0, 32'h3006},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h4000},
    {4'd2,  32'h0100, 32'h4000, 1'b0, 32'h4002},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h4100},
    {4'd3,  32'h0,    32'h5000, 1'b0, 32'h4102},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h5000},
    {4'd6,  32'h6000, 32'h0,    1'b0, 32'h5002},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h6000},
    {4'd9,  32'h0,    32'h0,    1'b0, 32'h6002},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h5004},
    {4'd7,  32'h0010, 32'h7000, 1'b0, 32'h5006},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h7010},
    {4'd8,  32'h0,    32'h8000, 1'b0, 32'h7012},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h8000},
    {4'd9,  32'h0,    32'h0,    1'b0, 32'h8002},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h7014},
    {4'd5,  32'h9000, 32'h0,    1'b1, 32'h7016},
    {4'd0,  32'h0,    32'h0,    1'b0, 32'h7018}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [31:0] d, input logic [31:0] r, input logic tv);
    cls = c; disp = d; rg = r; t = tv; retire = 1'b1;
    @(posedge clk);
    @(negedge clk);
    retire = 1'b0;
  endtask

  task automatic idle();
    retire = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset pc", pc, 32'h1000);
    chk("R1 reset sr", sr, 32'h7000_00F0);
    chk("R1 reset req", {31'h0, req}, 32'h0);
    chk("R1 reset code", {20'h0, code}, 32'h0);
    chk("R1 reset tra", tra, 32'h0);

    // R2..R5, R11: vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][100:97], VEC[i][96:65], VEC[i][64:33], VEC[i][32]);
      chk($sformatf("R2/R3/R4/R5/R11 vec%0d pc", i), pc, VEC[i][31:0]);
      chk($sformatf("R10 vec%0d no req", i), {31'h0, req}, 32'h0);
    end

    // R1: idle cycle holds state
    idle();
    chk("R1 hold pc", pc, 32'h7018);

    // R9: masked status writes
    step(4'd13, 32'h0, 32'hFFFF_FFFF, 1'b0);
    chk("R9 sr all ones", sr, 32'h7000_83F3);
    chk("R2 srwr step", pc, 32'h701A);
    step(4'd13, 32'h0, 32'h1234_5678, 1'b0);
    chk("R9 sr pattern", sr, 32'h1000_0270);

    // R7, R10: trap
    step(4'd11, 32'h0000_03AB, 32'h0, 1'b0);
    chk("R7 trap req", {31'h0, req}, 32'h1);
    chk("R7 trap code", {20'h0, code}, 32'h160);
    chk("R7 tra value", tra, 32'h2AC);
    chk("R10 trap pc hold", pc, 32'h701C);
    idle();
    chk("R10 req one cycle", {31'h0, req}, 32'h0);
    chk("R10 code quiet", {20'h0, code}, 32'h0);

    // R6: exception return restores status and PC
    step(4'd13, 32'h0, 32'h0, 1'b0);
    chk("R9 sr cleared", sr, 32'h0);
    step(4'd10, 32'h0, 32'h0, 1'b0);
    chk("R6 sr restored", sr, 32'h1000_0270);
    chk("R6 slot step", pc, 32'h7020);
    step(4'd0, 32'h0, 32'h0, 1'b0);
    chk("R6 pc restored", pc, 32'h701C);

    // R8: illegal outside a slot
    step(4'd12, 32'h0, 32'h0, 1'b0);
    chk("R8 ill code", {20'h0, code}, 32'h180);
    chk("R8 ill pc hold", pc, 32'h701C);

    // R8, R11: illegal inside a slot cancels branch
    step(4'd1, 32'hA000, 32'h0, 1'b0);
    chk("R3 bra step", pc, 32'h701E);
    step(4'd12, 32'h0, 32'h0, 1'b0);
    chk("R8 slot ill code", {20'h0, code}, 32'h1A0);
    chk("R11 slot ill pc hold", pc, 32'h701E);
    step(4'd0, 32'h0, 32'h0, 1'b0);
    chk("R11 cancelled step", pc, 32'h7020);

    // R8: branch inside a slot
    step(4'd1, 32'hA000, 32'h0, 1'b0);
    step(4'd4, 32'hB000, 32'h0, 1'b1);
    chk("R8 branch in slot code", {20'h0, code}, 32'h1A0);
    chk("R8 branch in slot pc", pc, 32'h7022);
    step(4'd0, 32'h0, 32'h0, 1'b0);
    chk("R11 after slot fault", pc, 32'h7024);

    // R8: unused class
    step(4'd14, 32'h0, 32'h0, 1'b0);
    chk("R8 unused class code", {20'h0, code}, 32'h180);
    chk("R10 spc via eret", pc, 32'h7024);

    finish_run();
  end

endmodule